// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable model of a single-port synchronous static RAM. Its word is four 9-bit byte lanes (36 bits), and its depth is set by an address-width parameter. Address, write data, chip enables, burst strobes and write controls are all captured on the rising clock edge. Reads are flow-through: the read word comes combinationally from the address register, so it is valid in the same cycle as the edge that loaded that address.

A burst begins on one of two start strobes. The processor-side strobe starts a read-only cycle. The controller-side strobe starts a cycle that may also write. After the start, a 2-bit internal counter steps the low address bits whenever the step input is low. A sequence-select input chooses linear or interleaved ordering. Writes are controlled per byte lane, and an all-lanes write input overrides the per-lane controls. A sleep input blocks writes and silences the output. The output-enable input gates the data output. An idle output reads as zero, because the model has no pads.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low and after its release, the device is deselected and `rdata_o` reads zero until a start cycle selects it.
- R2: On an edge where the controller-side strobe `start_ctl_n_i` is low and the processor-side start does not apply, `addr_i` becomes the burst base and the counter clears. If the device is selected, the write controls act on `addr_i` in that same cycle.
- R3: A start cycle selects the device only when `en_a_n_i`=0, `en_b_i`=1 and `en_c_n_i`=0. Otherwise the device stays deselected until the next start: no lane is written and `rdata_o` reads zero.
- R4: When `start_cpu_n_i`=0 and `en_a_n_i`=0, a start occurs and nothing is written on that edge, whatever the write inputs are. When `start_cpu_n_i`=0 and `en_a_n_i`=1, the processor-side strobe is ignored.
- R5: Outside a start, `next_n_i`=0 advances the 2-bit counter by one, modulo 4, and `next_n_i`=1 holds it. Either start strobe takes priority over `next_n_i`.
- R6: With `seq_sel_i`=0 (linear order), the address low two bits equal (base low bits + count) mod 4. The upper address bits stay equal to the base.
- R7: With `seq_sel_i`=1 (interleaved order), the address low two bits equal base low bits XOR count.
- R8: With `wr_all_n_i`=1 and `wr_lane_en_n_i`=0, each `lane_n_i[k]`=0 writes data bits 9k+8:9k only. With `wr_lane_en_n_i`=1, the lane inputs have no effect.
- R9: `wr_all_n_i`=0 writes all four lanes, whatever `wr_lane_en_n_i` and `lane_n_i` are.
- R10: Read data is flow-through. In the cycle after an edge, `rdata_o` shows the word stored at the address set by that edge, including data written on that edge. `out_en_n_i`=1 forces `rdata_o` to zero.
- R11: While `sleep_i`=1, no lane is written and `rdata_o` reads zero. Address and burst state still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr_i | input | ADDR_W | Word address loaded on a start |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Flow-through read data, zero when idle |
| en_a_n_i | input | 1 | Chip enable, active low; also gates the processor-side strobe |
| en_b_i | input | 1 | Chip enable, active high |
| en_c_n_i | input | 1 | Chip enable, active low |
| start_cpu_n_i | input | 1 | Processor-side burst start, active low, read only |
| start_ctl_n_i | input | 1 | Controller-side burst start, active low |
| next_n_i | input | 1 | Burst step, active low |
| wr_all_n_i | input | 1 | All-lanes write, active low |
| wr_lane_en_n_i | input | 1 | Enables per-lane writes, active low |
| lane_n_i | input | LANES | Per-lane write selects, active low |
| seq_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n_i | input | 1 | Output enable, active low |
| sleep_i | input | 1 | Sleep: blocks writes, silences output |

## Verification
The bench builds the block with `ADDR_W`=6 and the default four 9-bit lanes. The whole 64-word array can then be filled in 64 cycles, so every later read is compared against known contents. That small depth also makes a high base address reachable by both orderings, so wrap-around of the low bits is exercised, and the upper bits can be checked to stay put after wrap. A long random phase mixes strobes, enables, sequence changes mid-burst, sleep and byte masks against the behavioural model on every cycle.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   // Kind of cycle decoded on each rising edge
   typedef enum logic [1:0] {
      CYC_HOLD    = 2'd0,
      CYC_START_P = 2'd1,
      CYC_START_C = 2'd2,
      CYC_STEP    = 2'd3
   } cyc_kind_t;

   function automatic logic is_start(cyc_kind_t k);
      return (k == CYC_START_P) || (k == CYC_START_C);
   endfunction

endpackage

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
   import burst_sram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_a_n_i,
   input  logic             en_b_i,
   input  logic             en_c_n_i,
   input  logic             start_cpu_n_i,
   input  logic             start_ctl_n_i,
   input  logic             next_n_i,
   input  logic             wr_all_n_i,
   input  logic             wr_lane_en_n_i,
   input  logic [LANES-1:0] lane_n_i,
   input  logic             sleep_i,
   output cyc_kind_t        kind_o,
   output logic             sel_q_o,
   output logic [LANES-1:0] lane_we_o
);

   logic             enables_ok;
   logic             cpu_go;
   logic             sel_n;
   logic [LANES-1:0] lane_mask;

   assign enables_ok = !en_a_n_i && en_b_i && !en_c_n_i;
   assign cpu_go     = !start_cpu_n_i && !en_a_n_i;

   always_comb begin
      if (cpu_go)              kind_o = CYC_START_P;
      else if (!start_ctl_n_i) kind_o = CYC_START_C;
      else if (!next_n_i)      kind_o = CYC_STEP;
      else                     kind_o = CYC_HOLD;
   end

   assign sel_n = is_start(kind_o) ? enables_ok : sel_q_o;

   always_comb begin
      if (!wr_all_n_i)          lane_mask = '1;
      else if (!wr_lane_en_n_i) lane_mask = ~lane_n_i;
      else                      lane_mask = '0;
   end

   assign lane_we_o = (sel_n && (kind_o != CYC_START_P) && !sleep_i) ? lane_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q_o <= 1'b0;
      else        sel_q_o <= sel_n;
   end

   AST_CPU_START_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_cpu_n_i && !en_a_n_i) |-> (lane_we_o == '0)); // R4
   AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> (lane_we_o == '0)); // R11
   AST_START_OVER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_ctl_n_i && !next_n_i) |-> is_start(kind_o)); // R5
   AST_BAD_ENABLE_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_start(kind_o) && en_c_n_i) |=> !sel_q_o); // R3

endmodule

// File: rtl/burst_sram_addr_gen.sv
module burst_sram_addr_gen
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_kind_t         kind_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              seq_sel_i,
   output logic [ADDR_W-1:0] addr_n_o,
   output logic [ADDR_W-1:0] addr_q_o
);

   localparam int HI_W = ADDR_W - BURST_W;

   logic [ADDR_W-1:0]  base_q, base_n;
   logic [BURST_W-1:0] cnt_q, cnt_n;
   logic [BURST_W-1:0] low_n;

   always_comb begin
      base_n = base_q;
      cnt_n  = cnt_q;
      unique case (kind_i)
         CYC_START_P, CYC_START_C: begin
            base_n = addr_i;
            cnt_n  = '0;
         end
         CYC_STEP: cnt_n = cnt_q + 1'b1;
         default: ;
      endcase
   end

   always_comb begin
      if (seq_sel_i) low_n = base_n[BURST_W-1:0] ^ cnt_n;
      else           low_n = base_n[BURST_W-1:0] + cnt_n;
   end

   assign addr_n_o = {base_n[ADDR_W-1:BURST_W], low_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         cnt_q    <= '0;
         addr_q_o <= '0;
      end else begin
         base_q   <= base_n;
         cnt_q    <= cnt_n;
         addr_q_o <= addr_n_o;
      end
   end

   AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      is_start(kind_i) |=> (cnt_q == '0)); // R2
   AST_STEP_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == CYC_STEP) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1))); // R5
   AST_HOLD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == CYC_HOLD) |=> $stable(cnt_q)); // R5
   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      !is_start(kind_i) |=> (addr_q_o[ADDR_W-1 -: HI_W] == $past(addr_q_o[ADDR_W-1 -: HI_W]))); // R6

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        we_i,
   input  logic [ADDR_W-1:0]       waddr_i,
   input  logic [LANES*LANE_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0]       raddr_i,
   output logic [LANES*LANE_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we_i[k]) store[waddr_i] <= wdata_i[k*LANE_W +: LANE_W];
      end

      assign rdata_o[k*LANE_W +: LANE_W] = store[raddr_i];
   end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int LANES   = 4,
   parameter int LANE_W  = 9,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [LANES*LANE_W-1:0] wdata_i,
   output logic [LANES*LANE_W-1:0] rdata_o,
   input  logic                    en_a_n_i,
   input  logic                    en_b_i,
   input  logic                    en_c_n_i,
   input  logic                    start_cpu_n_i,
   input  logic                    start_ctl_n_i,
   input  logic                    next_n_i,
   input  logic                    wr_all_n_i,
   input  logic                    wr_lane_en_n_i,
   input  logic [LANES-1:0]        lane_n_i,
   input  logic                    seq_sel_i,
   input  logic                    out_en_n_i,
   input  logic                    sleep_i
);

   localparam int DATA_W = LANES * LANE_W;

   if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("burst_sram: BURST_W must be at least 1 and below ADDR_W");
   end
   if (ADDR_W > 16) begin : g_bad_depth
      $error("burst_sram: ADDR_W too large for a modelled array");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("burst_sram: lane count and width must be positive");
   end

   cyc_kind_t          kind;
   logic               sel_q;
   logic [LANES-1:0]   lane_we;
   logic [ADDR_W-1:0]  addr_n, addr_q;
   logic [DATA_W-1:0]  arr_rdata;

   burst_sram_ctl #(.LANES(LANES)) i_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_a_n_i      (en_a_n_i),
      .en_b_i        (en_b_i),
      .en_c_n_i      (en_c_n_i),
      .start_cpu_n_i (start_cpu_n_i),
      .start_ctl_n_i (start_ctl_n_i),
      .next_n_i      (next_n_i),
      .wr_all_n_i    (wr_all_n_i),
      .wr_lane_en_n_i(wr_lane_en_n_i),
      .lane_n_i      (lane_n_i),
      .sleep_i       (sleep_i),
      .kind_o        (kind),
      .sel_q_o       (sel_q),
      .lane_we_o     (lane_we)
   );

   burst_sram_addr_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) i_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind_i   (kind),
      .addr_i   (addr_i),
      .seq_sel_i(seq_sel_i),
      .addr_n_o (addr_n),
      .addr_q_o (addr_q)
   );

   burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
      .clk    (clk),
      .we_i   (lane_we),
      .waddr_i(addr_n),
      .wdata_i(wdata_i),
      .raddr_i(addr_q),
      .rdata_o(arr_rdata)
   );

   assign rdata_o = (sel_q && !out_en_n_i && !sleep_i) ? arr_rdata : '0;

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q |-> (rdata_o == '0)); // R3
   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> (rdata_o == '0)); // R11
   AST_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_all_n_i && !sleep_i && start_cpu_n_i && !start_ctl_n_i &&
       !en_a_n_i && en_b_i && !en_c_n_i) |-> (lane_we == '1)); // R9

endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;

   localparam int AW    = 6;
   localparam int LN    = 4;
   localparam int LW    = 9;
   localparam int DW    = LN * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic [DW-1:0] rdata;
   logic en_a_n, en_b, en_c_n, st_cpu_n, st_ctl_n, nxt_n, wall_n, wlane_n, seq, oe_n, slp;
   logic [LN-1:0] lane_n;

   always #10 clk = ~clk;

   burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .BURST_W(2)) i_burst_sram (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .en_a_n_i(en_a_n), .en_b_i(en_b), .en_c_n_i(en_c_n),
      .start_cpu_n_i(st_cpu_n), .start_ctl_n_i(st_ctl_n), .next_n_i(nxt_n),
      .wr_all_n_i(wall_n), .wr_lane_en_n_i(wlane_n), .lane_n_i(lane_n),
      .seq_sel_i(seq), .out_en_n_i(oe_n), .sleep_i(slp)
   );

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";

   // Behavioural reference model
   logic [DW-1:0] mem_m [DEPTH];
   int base_m = 0, cnt_m = 0, addr_m = 0;
   bit sel_m = 0;

   function automatic int burst_addr(int b, int c, bit m);
      int lo = b % 4;
      return (b - lo) + (m ? (lo ^ c) : ((lo + c) % 4));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_m = 0; cnt_m = 0; addr_m = 0; sel_m = 0;
      end else begin
         bit cpu_go, go;
         cpu_go = !st_cpu_n && !en_a_n;
         go     = cpu_go || !st_ctl_n;
         if (go) begin
            base_m = int'(addr);
            cnt_m  = 0;
            sel_m  = !en_a_n && en_b && !en_c_n;
         end else if (!nxt_n) begin
            cnt_m = (cnt_m + 1) % 4;
         end
         addr_m = burst_addr(base_m, cnt_m, seq);
         if (sel_m && !cpu_go && !slp)
            for (int k = 0; k < LN; k++)
               if (!wall_n || (!wlane_n && !lane_n[k]))
                  mem_m[addr_m][k*LW +: LW] = wdata[k*LW +: LW];
      end
   end

   function automatic logic [DW-1:0] expected();
      return (sel_m && !oe_n && !slp) ? mem_m[addr_m] : '0;
   endfunction

   task automatic chk(string t, logic [DW-1:0] got, logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", t, got, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      chk(tag, rdata, expected());
   endtask

   task automatic idle();
      en_a_n = 0; en_b = 1; en_c_n = 0;
      st_cpu_n = 1; st_ctl_n = 1; nxt_n = 1;
      wall_n = 1; wlane_n = 1; lane_n = '1;
      oe_n = 0; slp = 0;
   endtask

   task automatic start_ctl(int a);
      idle();
      st_ctl_n = 0;
      addr = AW'(a);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R1: watchdog actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      idle();
      seq = 0; addr = '0; wdata = '0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk("R1", rdata, '0);
      rst_n = 1;
      tick();
      chk("R1", rdata, '0);

      // R9 / R2: fill every word through all-lanes writes on controller starts
      tag = "R9";
      for (int a = 0; a < DEPTH; a++) begin
         start_ctl(a);
         wall_n = 0;
         wlane_n = 1; lane_n = '1;
         wdata = DW'({$urandom(), $urandom()});
         tick();
         chk("R2", rdata, mem_m[a]);
      end

      // R6 linear order from base 7: 7,4,5,6 then wrap back to 7
      tag = "R6";
      start_ctl(7); tick();
      chk("R6", rdata, mem_m[7]);
      idle(); nxt_n = 0; tick();
      chk("R6", rdata, mem_m[4]);
      tick(); tick(); tick();
      chk("R6", rdata, mem_m[7]);

      // R7 interleaved order from base 10: 10,11,8,9
      tag = "R7";
      seq = 1;
      start_ctl(10); tick();
      idle(); nxt_n = 0; tick();
      chk("R7", rdata, mem_m[11]);
      tick();
      chk("R7", rdata, mem_m[8]);
      tick();
      chk("R7", rdata, mem_m[9]);
      seq = 0;

      // R5: hold, and start beats step
      tag = "R5";
      idle(); tick(); tick();
      start_ctl(33); nxt_n = 0; tick();
      chk("R5", rdata, mem_m[33]);

      // R4: processor start ignores write inputs; ignored when en_a high
      tag = "R4";
      idle(); st_cpu_n = 0; addr = AW'(40); wall_n = 0; wdata = '1;
      tick();
      chk("R4", rdata, mem_m[40]);
      idle(); en_a_n = 1; st_cpu_n = 0; addr = AW'(50); nxt_n = 0;
      tick();
      chk("R4", rdata, mem_m[41]);

      // R8: per-lane writes; lanes 0 and 2 only, then lane selects with enable off
      tag = "R8";
      start_ctl(20); wlane_n = 0; lane_n = 4'b1010; wdata = '1; tick();
      idle(); wall_n = 1; wlane_n = 1; lane_n = 4'b0000; wdata = '0; tick();
      chk("R8", rdata, mem_m[20]);

      // R3: deselect through each enable
      tag = "R3";
      start_ctl(21); en_b = 0; wall_n = 0; wdata = '0; tick();
      chk("R3", rdata, '0);
      idle(); wall_n = 0; tick();
      start_ctl(22); en_c_n = 1; tick();
      start_ctl(23); en_a_n = 1; tick();
      chk("R3", rdata, '0);
      start_ctl(21); tick();

      // R10: output enable forces zero, flow-through after write
      tag = "R10";
      idle(); oe_n = 1; tick();
      chk("R10", rdata, '0);
      start_ctl(30); wall_n = 0; wdata = DW'(36'h123456789); tick();
      chk("R10", rdata, DW'(36'h123456789));

      // R11: sleep blocks writes and silences output
      tag = "R11";
      start_ctl(31); slp = 1; wall_n = 0; wdata = '0; tick();
      chk("R11", rdata, '0);
      idle(); tick();

      // Random mix, compared to the model each cycle
      tag = "R2";
      for (int i = 0; i < 2000; i++) begin
         st_cpu_n = ($urandom % 6) != 0;
         st_ctl_n = ($urandom % 4) != 0;
         nxt_n    = 1'($urandom);
         wall_n   = ($urandom % 5) != 0;
         wlane_n  = 1'($urandom);
         lane_n   = LN'($urandom);
         en_a_n   = ($urandom % 8) == 0;
         en_b     = ($urandom % 8) != 0;
         en_c_n   = ($urandom % 8) == 0;
         seq      = 1'($urandom);
         oe_n     = ($urandom % 8) == 0;
         slp      = ($urandom % 10) == 0;
         addr     = AW'($urandom);
         wdata    = DW'({$urandom(), $urandom()});
         tick();
      end

      summary();
      $finish;
   end

endmodule